// File: doc/BRIEF.md
# Bit-Slice Ripple-Carry Integer ALU

This block is the arithmetic and logic unit of a single-cycle integer datapath. It is purely combinational. It takes two operands of `WIDTH` bits (32 by default) and a 4-bit operation code. It returns a result word together with carry, overflow and zero flags, all in the same cycle. The arithmetic path is a chain of identical one-bit slices linked by a ripple carry. Each slice chooses its output bit through a small multiplexer.

Subtraction and both comparisons reuse the adder. B is inverted in every slice and a carry of 1 is injected into bit 0. The top slice reports its sum bit and its signed-overflow condition. From these, together with the final carry, the block forms a "less" bit that is fed back into bit 0 for the two set-on-less-than operations. Every other slice takes a constant 0 on its less input.

Top module: `rc_alu`

## Requirements
- R1: Code 0010 (signed add) returns the low `WIDTH` bits of A+B, and carry is the carry out of the top bit.
- R2: Code 0011 (unsigned add) gives the same result and carry as code 0010, and overflow is always 0.
- R3: Code 0110 (signed subtract) returns the low bits of A + ~B + 1. Carry is the carry out of that sum, which is 1 when no borrow occurs.
- R4: Code 0111 (unsigned subtract) gives the same result and carry as code 0110, and overflow is always 0.
- R5: The bitwise codes are 0000 AND, 0001 OR, 0100 XOR and 0101 NOR. Each returns its operation applied bit by bit, with carry and overflow both 0.
- R6: Code 1000 (signed less-than) returns 1 in bit 0, with all other bits 0, exactly when A < B as two's-complement numbers. This holds even when A−B overflows. Carry and overflow are 0.
- R7: Code 1001 (unsigned less-than) returns 1 in bit 0, with all other bits 0, exactly when A < B as unsigned numbers. Carry and overflow are 0.
- R8: Overflow is 1 only for codes 0010 and 0110. It is set when the true signed sum (or difference) falls outside the two's-complement range of `WIDTH` bits.
- R9: Zero is 1 exactly when every result bit is 0, for every code.
- R10: Codes 1010 through 1111 return a result of 0, with carry 0 and overflow 0. Zero is therefore 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| mode | input | 4 | Operation code |
| result | output | WIDTH | Operation result |
| carry | output | 1 | Top-bit adder carry (add and subtract codes only) |
| overflow | output | 1 | Signed overflow (signed add and subtract only) |
| zero | output | 1 | All result bits are 0 |

## Verification
The hardest case to reach from the ports is a signed comparison whose internal subtraction overflows. In that case the sign of the difference gives the wrong answer, and only the overflow correction in the fed-back less bit restores it. A random 32-bit operand pair hits this case only about a quarter of the time, and almost never at its edges. The bench therefore sweeps every operand pair and every code on a 4-bit instance, where each overflowing difference appears. On a 32-bit instance it crosses the extreme values 0x80000000, 0x7FFFFFFF and 0xFFFFFFFF with each other and with small values.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    MODE_AND  = 4'b0000,
    MODE_OR   = 4'b0001,
    MODE_ADD  = 4'b0010,
    MODE_ADDU = 4'b0011,
    MODE_XOR  = 4'b0100,
    MODE_NOR  = 4'b0101,
    MODE_SUB  = 4'b0110,
    MODE_SUBU = 4'b0111,
    MODE_SLT  = 4'b1000,
    MODE_SLTU = 4'b1001
  } alu_mode_e;

  // per-slice output selection
  typedef enum logic [2:0] {
    SEL_AND  = 3'd0,
    SEL_OR   = 3'd1,
    SEL_SUM  = 3'd2,
    SEL_LESS = 3'd3,
    SEL_XOR  = 3'd4,
    SEL_NOR  = 3'd5,
    SEL_ZERO = 3'd6
  } alu_sel_e;

  typedef struct packed {
    alu_sel_e sel;
    logic     binv;           // invert B in every slice
    logic     cin0;           // carry injected at bit 0
    logic     carry_en;       // report top carry
    logic     ovf_en;         // report signed overflow
    logic     less_unsigned;  // less bit from carry instead of sign
  } alu_ctl_t;

  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (x & ci) | (y & ci);
  endfunction

endpackage

// File: rtl/alu_mode_decode.sv
module alu_mode_decode
  import alu_pkg::*;
(
  input  logic [3:0] mode,
  output alu_ctl_t   ctl
);

  always_comb begin
    ctl.sel           = SEL_ZERO;
    ctl.binv          = 1'b0;
    ctl.cin0          = 1'b0;
    ctl.carry_en      = 1'b0;
    ctl.ovf_en        = 1'b0;
    ctl.less_unsigned = 1'b0;
    case (mode)
      MODE_AND:  ctl.sel = SEL_AND;
      MODE_OR:   ctl.sel = SEL_OR;
      MODE_XOR:  ctl.sel = SEL_XOR;
      MODE_NOR:  ctl.sel = SEL_NOR;
      MODE_ADD: begin
        ctl.sel      = SEL_SUM;
        ctl.carry_en = 1'b1;
        ctl.ovf_en   = 1'b1;
      end
      MODE_ADDU: begin
        ctl.sel      = SEL_SUM;
        ctl.carry_en = 1'b1;
      end
      MODE_SUB: begin
        ctl.sel      = SEL_SUM;
        ctl.binv     = 1'b1;
        ctl.cin0     = 1'b1;
        ctl.carry_en = 1'b1;
        ctl.ovf_en   = 1'b1;
      end
      MODE_SUBU: begin
        ctl.sel      = SEL_SUM;
        ctl.binv     = 1'b1;
        ctl.cin0     = 1'b1;
        ctl.carry_en = 1'b1;
      end
      MODE_SLT: begin
        ctl.sel  = SEL_LESS;
        ctl.binv = 1'b1;
        ctl.cin0 = 1'b1;
      end
      MODE_SLTU: begin
        ctl.sel           = SEL_LESS;
        ctl.binv          = 1'b1;
        ctl.cin0          = 1'b1;
        ctl.less_unsigned = 1'b1;
      end
      default: ctl.sel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
#(
  parameter bit IS_MSB = 1'b0
) (
  input  logic     a,
  input  logic     b,
  input  logic     binv,
  input  logic     cin,
  input  logic     less,
  input  alu_sel_e sel,
  output logic     res,
  output logic     cout,
  output logic     set,
  output logic     ovf_det
);

  logic bb;
  logic sum;

  assign bb   = b ^ binv;
  assign sum  = fa_sum(a, bb, cin);
  assign cout = fa_carry(a, bb, cin);

  always_comb begin
    case (sel)
      SEL_AND:  res = a & bb;
      SEL_OR:   res = a | bb;
      SEL_XOR:  res = a ^ bb;
      SEL_NOR:  res = ~(a | bb);
      SEL_SUM:  res = sum;
      SEL_LESS: res = less;
      default:  res = 1'b0;
    endcase
  end

  // only the top slice reports its sign and overflow
  generate
    if (IS_MSB) begin : g_msb
      assign set     = sum;
      assign ovf_det = cin ^ cout;
    end else begin : g_mid
      assign set     = 1'b0;
      assign ovf_det = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec,
  output logic             all_zero
);

  assign all_zero = ~|vec;

endmodule

// File: rtl/rc_alu.sv
module rc_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [3:0]       mode,
  output logic [WIDTH-1:0] result,
  output logic             carry,
  output logic             overflow,
  output logic             zero
);

  localparam int MSB = WIDTH - 1;

  alu_ctl_t         ctl;
  logic [WIDTH:0]   cchain;
  logic [WIDTH-1:0] set_v;
  logic [WIDTH-1:0] ovf_v;

  // named internal events, visible to the checker
  logic sum_msb;
  logic carry_msb;
  logic ovf_raw;
  logic less_bit;

  alu_mode_decode u_dec (
    .mode (mode),
    .ctl  (ctl)
  );

  assign cchain[0] = ctl.cin0;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic less_in;
      if (i == 0) begin : g_lsb
        assign less_in = less_bit;
      end else begin : g_upper
        assign less_in = 1'b0;
      end

      alu_bit_slice #(
        .IS_MSB (i == MSB)
      ) u_slice (
        .a       (a_in[i]),
        .b       (b_in[i]),
        .binv    (ctl.binv),
        .cin     (cchain[i]),
        .less    (less_in),
        .sel     (ctl.sel),
        .res     (result[i]),
        .cout    (cchain[i+1]),
        .set     (set_v[i]),
        .ovf_det (ovf_v[i])
      );
    end
  endgenerate

  assign sum_msb   = |set_v;
  assign ovf_raw   = |ovf_v;
  assign carry_msb = cchain[WIDTH];

  // signed: sign corrected by overflow; unsigned: borrow out
  assign less_bit = ctl.less_unsigned ? ~carry_msb : (sum_msb ^ ovf_raw);

  assign carry    = ctl.carry_en & carry_msb;
  assign overflow = ctl.ovf_en & ovf_raw;

  alu_zero_detect #(
    .WIDTH (WIDTH)
  ) u_zero (
    .vec      (result),
    .all_zero (zero)
  );

endmodule

// File: rtl/rc_alu_chk.sv
module rc_alu_chk
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [3:0]       mode,
  input logic [WIDTH-1:0] result,
  input logic             carry,
  input logic             overflow,
  input logic             zero,
  input logic             less_bit
);

  always_comb begin
    if (mode == MODE_ADD || mode == MODE_ADDU) begin
      AST_ADD_SUM: assert ({carry, result} == ({1'b0, a_in} + {1'b0, b_in}))
        else $error("add mismatch"); // R1
    end
    if (mode == MODE_ADDU || mode == MODE_SUBU) begin
      AST_NO_OVERFLOW: assert (!overflow)
        else $error("unsigned overflow"); // R2
    end
    if (mode == MODE_AND || mode == MODE_OR || mode == MODE_XOR || mode == MODE_NOR) begin
      AST_LOGIC_QUIET: assert (!carry && !overflow)
        else $error("logic flags"); // R5
    end
    if (mode == MODE_SLT) begin
      AST_SLT_VALUE: assert (result == {{(WIDTH-1){1'b0}}, ($signed(a_in) < $signed(b_in))})
        else $error("slt mismatch"); // R6
    end
    if (mode == MODE_SLTU) begin
      AST_SLTU_VALUE: assert (result == {{(WIDTH-1){1'b0}}, (a_in < b_in)} && less_bit == (a_in < b_in))
        else $error("sltu mismatch"); // R7
    end
    if (mode > 4'b1001) begin
      AST_UNUSED_QUIET: assert (result == '0 && !carry && !overflow && zero)
        else $error("unused code not quiet"); // R10
    end
  end

endmodule

bind rc_alu rc_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_in     (a_in),
  .b_in     (b_in),
  .mode     (mode),
  .result   (result),
  .carry    (carry),
  .overflow (overflow),
  .zero     (zero),
  .less_bit (less_bit)
);

// File: tb/rc_alu_tb.sv
module rc_alu_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] a32, b32, r32;
  logic [3:0]  m32;
  logic        c32, v32, z32;
  logic [3:0]  a4, b4, r4;
  logic [3:0]  m4;
  logic        c4, v4, z4;

  rc_alu #(.WIDTH(32)) u_dut (
    .a_in(a32), .b_in(b32), .mode(m32),
    .result(r32), .carry(c32), .overflow(v32), .zero(z32)
  );

  rc_alu #(.WIDTH(4)) u_dut4 (
    .a_in(a4), .b_in(b4), .mode(m4),
    .result(r4), .carry(c4), .overflow(v4), .zero(z4)
  );

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd2: return "R1";
      4'd3: return "R2";
      4'd6: return "R3";
      4'd7: return "R4";
      4'd0, 4'd1, 4'd4, 4'd5: return "R5";
      4'd8: return "R6";
      4'd9: return "R7";
      default: return "R10";
    endcase
  endfunction

  // arithmetic model, independent of the slice structure
  task automatic model(input int w, input longint unsigned a, input longint unsigned b,
                       input logic [3:0] m, output longint unsigned r,
                       output bit c, output bit v);
    longint unsigned mask = (64'd1 << w) - 1;
    longint signed   half = longint'(64'd1 << (w - 1));
    longint signed   sa = (a >= half) ? longint'(a) - 2 * half : longint'(a);
    longint signed   sb = (b >= half) ? longint'(b) - 2 * half : longint'(b);
    longint unsigned t;
    r = 0; c = 0; v = 0;
    case (m)
      4'd0: r = a & b;
      4'd1: r = a | b;
      4'd4: r = a ^ b;
      4'd5: r = ~(a | b) & mask;
      4'd2, 4'd3: begin
        t = a + b; r = t & mask; c = t[w];
        if (m == 4'd2) v = (sa + sb > half - 1) || (sa + sb < -half);
      end
      4'd6, 4'd7: begin
        t = a + ((~b) & mask) + 1; r = t & mask; c = t[w];
        if (m == 4'd6) v = (sa - sb > half - 1) || (sa - sb < -half);
      end
      4'd8: r = (sa < sb) ? 1 : 0;
      4'd9: r = (a < b) ? 1 : 0;
      default: r = 0;
    endcase
  endtask

  task automatic compare(input int w, input longint unsigned a, input longint unsigned b,
                         input logic [3:0] m, input longint unsigned ar,
                         input bit ac, input bit av, input bit az);
    longint unsigned er;
    bit ec, ev;
    model(w, a, b, m, er, ec, ev);
    checks++;
    if (ar != er || ac != ec) begin
      errors++;
      $display("FAIL %s w=%0d a=%h b=%h mode=%b result/carry actual %h/%0b expected %h/%0b",
               tag_of(m), w, a, b, m, ar, ac, er, ec);
    end
    checks++;
    if (av != ev) begin
      errors++;
      $display("FAIL R8 w=%0d a=%h b=%h mode=%b overflow actual %0b expected %0b",
               w, a, b, m, av, ev);
    end
    checks++;
    if (az != (er == 0)) begin
      errors++;
      $display("FAIL R9 w=%0d a=%h b=%h mode=%b zero actual %0b expected %0b",
               w, a, b, m, az, (er == 0));
    end
  endtask

  task automatic run32(input logic [31:0] a, input logic [31:0] b, input logic [3:0] m);
    @(posedge clk);
    a32 = a; b32 = b; m32 = m;
    @(negedge clk);
    compare(32, a, b, m, r32, c32, v32, z32);
  endtask

  task automatic run4(input logic [3:0] a, input logic [3:0] b, input logic [3:0] m);
    @(posedge clk);
    a4 = a; b4 = b; m4 = m;
    @(negedge clk);
    compare(4, a, b, m, r4, c4, v4, z4);
  endtask

  logic [31:0] corners [8] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000,
                                32'hFFFFFFFF, 32'h80000001, 32'h7FFFFFFE, 32'h55AA33CC};

  initial begin
    a32 = '0; b32 = '0; m32 = 4'd0;
    a4  = '0; b4  = '0; m4  = 4'd0;
    // initial state: AND of zeros gives zero result, flags clear (R5, R9)
    @(negedge clk);
    compare(32, 0, 0, 4'd0, r32, c32, v32, z32);

    // exhaustive sweep on the narrow instance, all sixteen codes (R1..R10)
    for (int m = 0; m < 16; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run4(a[3:0], b[3:0], m[3:0]);

    // wide corners crossed with every code, incl. overflowing slt (R6, R8)
    for (int m = 0; m < 16; m++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run32(corners[i], corners[j], m[3:0]);

    // wide random operands
    for (int k = 0; k < 300; k++)
      for (int m = 0; m < 11; m++)
        run32($urandom, $urandom, m[3:0]);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule